// File: doc/BRIEF.md
# Link Token Resynchronization Controller

This block holds the recovery control for both ends of a three-wire serial link whose transmit and receive sides each circulate a protocol-state token around a ring of bit cells. A lost or corrupted bit leaves the two rings in different protocol states, and from then on every later word decodes wrongly. The controller repairs this. The two ends re-seed their ring state to the initial state at the same point in the word stream. There is no retransmission.

Flow control uses credits. A bounded control queue runs from the receive end to the transmit end. It carries one-bit tokens: 0 is a normal token, 1 is a sync token. Each normal token is a credit for one 8-bit word, and the queue starts full of normal tokens.

When a received word is good, the receive end returns one normal token and lets its ring advance. When a word is flagged bad, the receive end does four things in order:
- It holds its ring still.
- It flushes the queue with as many sync tokens as the queue is deep.
- It re-seeds its ring for one cycle.
- It refills the queue with the same number of normal tokens.

At the transmit end, a sync token arms a seed flag and sends nothing. The next normal token sends its word with a ring re-seed and disarms the flag.

Each end has a ring-head stage. On a pass command it forwards the incoming protocol state. On a seed command it emits state 0. With no command it produces no valid output, which stalls the ring.

Top module: `link_resync_ctrl`

## Requirements
- R1: After reset the control queue holds QDEPTH normal tokens (code 0). With send-ready held high, the transmit end sends exactly QDEPTH words, each with a pass command, and then sends nothing more until a credit returns.
- R2: Each ring-head stage works as follows. With no command, its output valid is low. With a pass command it outputs its incoming state unchanged. With a seed command it outputs state 0.
- R3: In the run state, a word with the error flag low produces the following in the same cycle: the decoded-word strobe with the word's data, and a pass command on the receive ring. One normal token is also returned to the queue, so the transmit end can send one more word.
- R4: In the run state, a word with the error flag high is not decoded and gives no receive ring command. The receive end then enters the flush state.
- R5: Words that arrive in the flush or seed states are dropped. They are never decoded, and they cause no pass command.
- R6: In the flush state, one sync token is pushed in each cycle that the queue has room. After QDEPTH of them, the receive ring outputs state 0 for exactly one cycle. With the queue never full, this is QDEPTH+1 cycles after the error cycle. The refill state follows, pushing QDEPTH normal tokens.
- R7: The transmit end pops a sync token (code 1) whether or not send-ready is high. The pop sends no word and arms the seed flag.
- R8: A normal token popped while the seed flag is armed sends its word with a seed command, so the transmit ring output is 0, and disarms the flag. Later normal tokens send with a pass command.
- R9: In the refill state, a good word is decoded with a pass command and adds one more normal token to the refill. A bad word in the refill state is dropped and does not start another flush.
- R10: The transmit end sends no word while send-ready is low or the queue is empty.
- R11: The receive end never pushes a token into a full queue. In the flush and refill states it waits until there is room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word_valid | input | 1 | A received word is present this cycle |
| rx_word_err | input | 1 | The error check flagged the present word |
| rx_word_data | input | WORD_W | Data of the present received word |
| rx_ring_in | input | 2 | Protocol state arriving at the receive ring head |
| tx_send_ready | input | 1 | The transmit core has a word ready to send |
| tx_ring_in | input | 2 | Protocol state arriving at the transmit ring head |
| rx_dec_valid | output | 1 | The received word is accepted for decoding |
| rx_dec_data | output | WORD_W | Data of the accepted word |
| rx_ring_out_valid | output | 1 | The receive ring head advances this cycle |
| rx_ring_out | output | 2 | State leaving the receive ring head |
| tx_word_go | output | 1 | The transmit end sends one word this cycle |
| tx_ring_out_valid | output | 1 | The transmit ring head advances this cycle |
| tx_ring_out | output | 2 | State leaving the transmit ring head |

## Verification
The bench aims words at each receive phase:
- A bad word, and a good word during the flush, must both stay undecoded. A design that decoded them would deliver data out of step with the re-seeded rings.
- The seed cycle must fall exactly QDEPTH+1 cycles after the error. A miscounted flush would seed early or late, or leave stale normal tokens ahead of the syncs.
- On the transmit side, the bench counts words across a flush. Only the first word after recovery may carry state 0. A transmit end that sent a word for a sync token, or that never disarmed its flag, would show up as a wrong word count or a wrong ring state.
- A good word during the refill must add a credit, and a bad one there must not restart recovery. A design that got either wrong would lose a credit for good, or start a second seed.

// File: rtl/link_resync_pkg.sv
package link_resync_pkg;

  typedef logic [1:0] ring_state_t;
  typedef logic [15:0] tally_t;

  localparam ring_state_t RING_SEED_STATE = 2'd0;

  // control token kinds carried on the queue
  localparam logic TOK_NORMAL = 1'b0;
  localparam logic TOK_SYNC   = 1'b1;

  // ring-head commands
  localparam logic RCMD_PASS = 1'b0;
  localparam logic RCMD_SEED = 1'b1;

  typedef enum logic [1:0] {
    RX_RUN    = 2'd0,
    RX_FLUSH  = 2'd1,
    RX_SEED   = 2'd2,
    RX_REFILL = 2'd3
  } rx_phase_e;

  // state leaving a ring head for a given command
  function automatic ring_state_t ring_pick(logic seed_cmd, ring_state_t incoming);
    return seed_cmd ? RING_SEED_STATE : incoming;
  endfunction

  // tokens still owed during refill: one fewer per push, one more per accepted word
  function automatic tally_t refill_left(tally_t left, logic pushed, logic taken);
    return left - {15'd0, pushed} + {15'd0, taken};
  endfunction

endpackage

// File: rtl/ring_head_stage.sv
module ring_head_stage
  import link_resync_pkg::*;
(
  input  logic        cmd_valid,
  input  logic        cmd_seed,
  input  ring_state_t state_in,
  output logic        state_valid,
  output ring_state_t state_out
);

  // no command means no progress: the ring behind this stage stalls
  assign state_valid = cmd_valid;
  assign state_out   = ring_pick(cmd_seed, state_in);

endmodule

// File: rtl/ctl_token_queue.sv
module ctl_token_queue
  import link_resync_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_kind,
  input  logic pop,
  output logic full,
  output logic empty,
  output logic head_kind
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] slot;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [LW-1:0]    level;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == LVL_FULL);
  assign empty     = (level == '0);
  assign head_kind = slot[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot   <= '0;          // every slot a normal token
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= LVL_FULL;    // queue starts full of credits
    end else begin
      if (do_push) begin
        slot[wr_ptr] <= push_kind;
        wr_ptr       <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

endmodule

// File: rtl/rx_resync_fsm.sv
module rx_resync_fsm
  import link_resync_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      word_valid,
  input  logic      word_err,
  input  logic      q_full,
  output logic      dec_valid,
  output logic      ring_cmd_valid,
  output logic      ring_cmd_seed,
  output logic      tok_push,
  output logic      tok_kind,
  output rx_phase_e phase
);

  localparam int RW = $clog2(2 * DEPTH + 2);
  localparam logic [RW-1:0] CNT_DEPTH = RW'(DEPTH);
  localparam logic [RW-1:0] CNT_ONE   = RW'(1);

  rx_phase_e      phase_n;
  logic [RW-1:0]  cnt, cnt_n;
  logic           take;

  always_comb begin
    phase_n        = phase;
    cnt_n          = cnt;
    dec_valid      = 1'b0;
    ring_cmd_valid = 1'b0;
    ring_cmd_seed  = RCMD_PASS;
    tok_push       = 1'b0;
    tok_kind       = TOK_NORMAL;
    take           = 1'b0;
    case (phase)
      RX_RUN: begin
        if (word_valid) begin
          if (word_err) begin
            phase_n = RX_FLUSH;       // hold the ring, start flushing
            cnt_n   = CNT_DEPTH;
          end else begin
            dec_valid      = 1'b1;
            ring_cmd_valid = 1'b1;
            tok_push       = 1'b1;    // credit for the next word
          end
        end
      end
      RX_FLUSH: begin
        tok_push = !q_full;
        tok_kind = TOK_SYNC;
        if (tok_push) begin
          cnt_n = cnt - 1'b1;
          if (cnt == CNT_ONE) phase_n = RX_SEED;
        end
      end
      RX_SEED: begin
        ring_cmd_valid = 1'b1;
        ring_cmd_seed  = RCMD_SEED;
        phase_n        = RX_REFILL;
        cnt_n          = CNT_DEPTH;
      end
      RX_REFILL: begin
        take           = word_valid && !word_err;
        dec_valid      = take;
        ring_cmd_valid = take;
        tok_push       = !q_full;
        cnt_n          = RW'(refill_left(16'(cnt), tok_push, take));
        if (cnt_n == '0) phase_n = RX_RUN;
      end
      default: phase_n = RX_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= RX_RUN;
      cnt   <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/tx_resync_ctl.sv
module tx_resync_ctl
  import link_resync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic send_ready,
  input  logic q_empty,
  input  logic q_head,
  output logic pop,
  output logic word_go,
  output logic ring_cmd_seed,
  output logic seed_flag
);

  // sync tokens drain without waiting for the transmit core
  assign pop           = !q_empty && (q_head == TOK_SYNC || send_ready);
  assign word_go       = pop && (q_head == TOK_NORMAL);
  assign ring_cmd_seed = seed_flag ? RCMD_SEED : RCMD_PASS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seed_flag <= 1'b0;
    end else if (pop) begin
      seed_flag <= (q_head == TOK_SYNC);
    end
  end

endmodule

// File: rtl/link_resync_ctrl.sv
module link_resync_ctrl
  import link_resync_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_word_valid,
  input  logic              rx_word_err,
  input  logic [WORD_W-1:0] rx_word_data,
  input  logic [1:0]        rx_ring_in,
  input  logic              tx_send_ready,
  input  logic [1:0]        tx_ring_in,
  output logic              rx_dec_valid,
  output logic [WORD_W-1:0] rx_dec_data,
  output logic              rx_ring_out_valid,
  output logic [1:0]        rx_ring_out,
  output logic              tx_word_go,
  output logic              tx_ring_out_valid,
  output logic [1:0]        tx_ring_out
);

  // internal events, named for the checker
  logic      q_push, q_push_kind, q_pop, q_full, q_empty, q_head;
  logic      rx_cmd_valid, rx_cmd_seed, tx_cmd_seed, tx_seed_flag;
  rx_phase_e rx_phase;

  assign rx_dec_data = rx_word_data;

  ctl_token_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_kind (q_push_kind),
    .pop       (q_pop),
    .full      (q_full),
    .empty     (q_empty),
    .head_kind (q_head)
  );

  rx_resync_fsm #(.DEPTH(QDEPTH)) u_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .word_valid     (rx_word_valid),
    .word_err       (rx_word_err),
    .q_full         (q_full),
    .dec_valid      (rx_dec_valid),
    .ring_cmd_valid (rx_cmd_valid),
    .ring_cmd_seed  (rx_cmd_seed),
    .tok_push       (q_push),
    .tok_kind       (q_push_kind),
    .phase          (rx_phase)
  );

  tx_resync_ctl u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .send_ready    (tx_send_ready),
    .q_empty       (q_empty),
    .q_head        (q_head),
    .pop           (q_pop),
    .word_go       (tx_word_go),
    .ring_cmd_seed (tx_cmd_seed),
    .seed_flag     (tx_seed_flag)
  );

  ring_head_stage u_rx_head (
    .cmd_valid   (rx_cmd_valid),
    .cmd_seed    (rx_cmd_seed),
    .state_in    (rx_ring_in),
    .state_valid (rx_ring_out_valid),
    .state_out   (rx_ring_out)
  );

  ring_head_stage u_tx_head (
    .cmd_valid   (tx_word_go),
    .cmd_seed    (tx_cmd_seed),
    .state_in    (tx_ring_in),
    .state_valid (tx_ring_out_valid),
    .state_out   (tx_ring_out)
  );

endmodule

// File: rtl/link_resync_chk.sv
module link_resync_chk
  import link_resync_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_word_valid,
  input logic       rx_word_err,
  input logic       rx_dec_valid,
  input logic       tx_send_ready,
  input logic       tx_word_go,
  input logic       q_push,
  input logic       q_push_kind,
  input logic       q_full,
  input logic       q_pop,
  input logic       q_head,
  input logic [1:0] rx_phase,
  input logic       tx_seed_flag
);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full);

  assert_err_starts_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_phase == RX_RUN && rx_word_valid && rx_word_err) |=> rx_phase == RX_FLUSH);

  assert_drop_in_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_phase == RX_FLUSH || rx_phase == RX_SEED) |-> !rx_dec_valid);

  assert_seed_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_phase == RX_SEED) |=> rx_phase == RX_REFILL);

  assert_sync_sends_nothing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_head == TOK_SYNC) |-> (!tx_word_go ##1 tx_seed_flag));

  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_go && tx_seed_flag) |=> !tx_seed_flag);

  assert_good_word_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_phase == RX_RUN && rx_dec_valid) |-> (q_push && q_push_kind == TOK_NORMAL));

  assert_no_send_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_send_ready |-> !tx_word_go);

  assert_refill_keeps_going_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_phase == RX_REFILL) |=> (rx_phase == RX_REFILL || rx_phase == RX_RUN));

endmodule

bind link_resync_ctrl link_resync_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_word_valid (rx_word_valid),
  .rx_word_err   (rx_word_err),
  .rx_dec_valid  (rx_dec_valid),
  .tx_send_ready (tx_send_ready),
  .tx_word_go    (tx_word_go),
  .q_push        (q_push),
  .q_push_kind   (q_push_kind),
  .q_full        (q_full),
  .q_pop         (q_pop),
  .q_head        (q_head),
  .rx_phase      (rx_phase),
  .tx_seed_flag  (tx_seed_flag)
);

// File: tb/link_resync_ctrl_test.sv
module link_resync_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;
  localparam int WW = 8;
  localparam logic [1:0] TX_IN = 2'd2;
  localparam logic [1:0] RX_IN = 2'd1;

  logic          clk, rst_n;
  logic          rx_word_valid, rx_word_err, tx_send_ready;
  logic [WW-1:0] rx_word_data, rx_dec_data;
  logic [1:0]    rx_ring_in, tx_ring_in, rx_ring_out, tx_ring_out;
  logic          rx_dec_valid, rx_ring_out_valid, tx_word_go, tx_ring_out_valid;

  int n_chk = 0, n_bad = 0, tx_words = 0, rx_seeds = 0;
  bit finished = 0;
  logic [1:0]    exp_tx[$];
  logic [WW-1:0] exp_rx[$];

  link_resync_ctrl #(.QDEPTH(QD), .WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_word_valid(rx_word_valid), .rx_word_err(rx_word_err), .rx_word_data(rx_word_data),
    .rx_ring_in(rx_ring_in), .tx_send_ready(tx_send_ready), .tx_ring_in(tx_ring_in),
    .rx_dec_valid(rx_dec_valid), .rx_dec_data(rx_dec_data),
    .rx_ring_out_valid(rx_ring_out_valid), .rx_ring_out(rx_ring_out),
    .tx_word_go(tx_word_go), .tx_ring_out_valid(tx_ring_out_valid), .tx_ring_out(tx_ring_out)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // one cycle: drive after the rising edge, leave the caller at the falling edge
  task automatic step(logic rdy, logic v, logic e, logic [WW-1:0] d);
    @(posedge clk); #1;
    tx_send_ready = rdy;
    rx_word_valid = v;
    rx_word_err   = e;
    rx_word_data  = d;
    @(negedge clk);
  endtask

  task automatic idle(logic rdy, int n);
    for (int i = 0; i < n; i++) step(rdy, 1'b0, 1'b0, '0);
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (tx_word_go) begin
        tx_words++;
        if (exp_tx.size() == 0)
          check(0, "R10", "unexpected transmit word", int'(tx_ring_out), -1);
        else begin
          logic [1:0] e;
          e = exp_tx.pop_front();
          check(tx_ring_out_valid && tx_ring_out == e, "R8/R2", "transmit ring state",
                int'(tx_ring_out), int'(e));
        end
      end
      if (rx_dec_valid) begin
        if (exp_rx.size() == 0)
          check(0, "R5", "unexpected decoded word", int'(rx_dec_data), -1);
        else begin
          logic [WW-1:0] e;
          e = exp_rx.pop_front();
          check(rx_dec_data == e, "R3", "decoded data", int'(rx_dec_data), int'(e));
          check(rx_ring_out_valid && rx_ring_out == RX_IN, "R2", "receive ring pass",
                int'(rx_ring_out), int'(RX_IN));
        end
      end
      if (rx_ring_out_valid && !rx_dec_valid) rx_seeds++;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; tx_send_ready = 1'b0; rx_word_valid = 1'b0; rx_word_err = 1'b0;
    rx_word_data = '0; rx_ring_in = RX_IN; tx_ring_in = TX_IN;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!tx_word_go, "R10", "no send while not ready", int'(tx_word_go), 0);
    check(!rx_ring_out_valid, "R2", "receive ring stalled", int'(rx_ring_out_valid), 0);
    check(!tx_ring_out_valid, "R2", "transmit ring stalled", int'(tx_ring_out_valid), 0);
    check(!rx_dec_valid, "R3", "no decode at reset", int'(rx_dec_valid), 0);

    // R1: initial credits
    for (int i = 0; i < QD; i++) exp_tx.push_back(TX_IN);
    idle(1'b1, QD + 3);
    check(tx_words == QD, "R1", "words on initial credits", tx_words, QD);

    // R3: good words return credits
    for (int i = 0; i < 3; i++) begin
      exp_rx.push_back(WW'(8'hA0 + i));
      exp_tx.push_back(TX_IN);
      step(1'b1, 1'b1, 1'b0, WW'(8'hA0 + i));
    end
    idle(1'b1, 3);
    check(tx_words == QD + 3, "R3", "credits returned", tx_words, QD + 3);

    // R4..R8: error and recovery, transmit core not ready during flush
    step(1'b0, 1'b1, 1'b1, 8'hEE);
    check(!rx_dec_valid, "R4", "bad word decoded", int'(rx_dec_valid), 0);
    check(!rx_ring_out_valid, "R4", "ring moved on bad word", int'(rx_ring_out_valid), 0);
    idle(1'b0, 1);
    step(1'b0, 1'b1, 1'b0, 8'h55);
    check(!rx_dec_valid, "R5", "word decoded in flush", int'(rx_dec_valid), 0);
    check(!rx_ring_out_valid, "R5", "ring moved in flush", int'(rx_ring_out_valid), 0);
    idle(1'b0, 1);
    check(!tx_word_go, "R7", "sync produced a word", int'(tx_word_go), 0);
    idle(1'b0, 1);
    step(1'b0, 1'b1, 1'b0, 8'h66);
    check(rx_ring_out_valid && rx_ring_out == 2'd0, "R6", "seed QDEPTH+1 cycles after error",
          int'(rx_ring_out_valid), 1);
    check(!rx_dec_valid, "R5", "word decoded in seed cycle", int'(rx_dec_valid), 0);
    idle(1'b0, 6);
    check(tx_words == QD + 3, "R7", "words during flush", tx_words, QD + 3);
    exp_tx.push_back(2'd0);
    for (int i = 0; i < QD - 1; i++) exp_tx.push_back(TX_IN);
    idle(1'b1, QD + 3);
    check(tx_words == 2 * QD + 3, "R6", "refill credit count", tx_words, 2 * QD + 3);
    check(rx_seeds == 1, "R6", "receive seeds", rx_seeds, 1);

    // R9: words during refill
    step(1'b0, 1'b1, 1'b1, 8'hEE);
    idle(1'b0, 5);
    exp_rx.push_back(8'h77);
    step(1'b0, 1'b1, 1'b0, 8'h77);
    check(rx_dec_valid, "R9", "good word in refill", int'(rx_dec_valid), 1);
    step(1'b0, 1'b1, 1'b1, 8'h88);
    check(!rx_dec_valid, "R9", "bad word in refill", int'(rx_dec_valid), 0);
    idle(1'b0, 6);
    exp_tx.push_back(2'd0);
    for (int i = 0; i < QD; i++) exp_tx.push_back(TX_IN);
    idle(1'b1, QD + 6);
    check(tx_words == 3 * QD + 4, "R9", "refill with extra credit", tx_words, 3 * QD + 4);
    check(rx_seeds == 2, "R9", "no second flush", rx_seeds, 2);

    // back in run state
    exp_rx.push_back(8'h99);
    exp_tx.push_back(TX_IN);
    step(1'b1, 1'b1, 1'b0, 8'h99);
    idle(1'b1, 3);
    check(tx_words == 3 * QD + 5, "R3", "credit after recovery", tx_words, 3 * QD + 5);
    check(exp_tx.size() == 0, "R8", "transmit words left", exp_tx.size(), 0);
    check(exp_rx.size() == 0, "R3", "decoded words left", exp_rx.size(), 0);
    summary();
  end

endmodule